// File: doc/BRIEF.md
# Interrupt Distributor Control and Routing Registers

This block is the register front end of an interrupt distributor. It answers a 32-bit register bus for three global words (control, type and implementer), a small identification window, and a file of 64-bit routing registers, one per interrupt ID. The control word carries a single global enable; turning it on also produces a one-cycle wake pulse that the delivery logic uses to re-examine its pending work. The type word is not stored: it is built from two strap inputs, the number of shared interrupts wired up and whether message-signalled interrupts exist.

Each routing register holds a 24-bit affinity target for one shared interrupt. Those targets leave the block as a flat vector, one 24-bit slice per shared interrupt, so the delivery logic can steer each interrupt. The 32 private interrupt IDs and any ID at or past the strapped shared count have no routing storage. Only aligned 32-bit accesses are accepted. Pending state, priority and delivery live elsewhere.

A read is requested with `bus_rd` and answered one cycle later on `bus_rdata` with `bus_rvalid` high for that cycle. A write with `bus_wr` takes effect at the same clock edge. The bus has no back-pressure: every request is accepted in the cycle it is presented.

Top module: `intdist_regs`

## Requirements
- R1: A read of offset 0x0000 returns 0x50 with bit 0 equal to the global enable (bit 4 routing-enable and bit 6 security-disable are always 1); a read of offset 0x000C returns zero.
- R2: A write to offset 0x0000 sets the global enable `dist_enable` to write-data bit 0 and changes nothing else; the enable is 0 after reset.
- R3: `dist_wake` is high for exactly one cycle, in the cycle after a control write that takes the enable from 0 to 1, and is never high otherwise.
- R4: The type word (offset 0x0004) bits [4:0] equal ((cfg_shared_cnt + 32) / 32) - 1.
- R5: Type word bits [23:19] hold the ID width minus one: 9 when `cfg_msg_irq` is 0, 15 when it is 1; bit 17 equals `cfg_msg_irq`; all other bits are zero.
- R6: The implementer word (offset 0x0008) returns the IIDR_VALUE parameter; writes to the type and implementer words have no effect.
- R7: Offset 0xFFE8 of the identification window reads 0x3B; any other offset in 0xFFD0..0xFFFF reads zero.
- R8: Routing register for interrupt ID n sits at 0x6000 + 8*n; a write to its lower word stores write-data bits [23:0], which then read back in bits [23:0] (bits [31:24] zero) and drive `route_aff[(n-32)*24 +: 24]`; all targets reset to 0.
- R9: The upper word of every routing register (lower-word address + 4) reads zero and ignores writes.
- R10: Routing registers of IDs 0..31 and of IDs at or above 32 + cfg_shared_cnt read zero and ignore writes.
- R11: An access whose `bus_size` is not 2 (word; 0 is byte, 1 half-word) or whose address bits [1:0] are not zero reads zero and has no effect.
- R12: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high, with the read value on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address within the distributor frame |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| cfg_shared_cnt | input | CNT_W | Strap: number of shared interrupts wired |
| cfg_msg_irq | input | 1 | Strap: message-signalled interrupts supported |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| dist_enable | output | 1 | Global distributor enable |
| dist_wake | output | 1 | One-cycle pulse on enable going high |
| route_aff | output | MAX_SHARED*24 | Affinity target per shared interrupt |

## Verification
The bench builds the block with MAX_SHARED set to 48 and drives the shared-count strap to 40, so the strap cut-off falls inside the stored range and the last wired ID (71) and the first unwired one (72) can both be probed. The message strap is driven both ways, and the strap is also moved to 100 to give a second lines-count value. Accesses of every rejected form are aimed at the control word and a routing register, whose contents are then read back.

// File: rtl/intdist_pkg.sv
package intdist_pkg;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 32;
  localparam int AFF_W       = 24;
  localparam int PRIV_CNT    = 32;
  localparam int GID_W       = 10;
  localparam int LOW_ID_BITS = 10;
  localparam int MSG_ID_BITS = 16;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 16'h0000;
  localparam logic [ADDR_W-1:0] OFF_TYPE   = 16'h0004;
  localparam logic [ADDR_W-1:0] OFF_IMPL   = 16'h0008;
  localparam logic [ADDR_W-1:0] ROUTE_LO   = 16'h6000;
  localparam logic [ADDR_W-1:0] ROUTE_HI   = 16'h8000;
  localparam logic [ADDR_W-1:0] OFF_IDENT2 = 16'hFFE8;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TYPE,
    SEL_IMPL,
    SEL_ROUTE,
    SEL_IDENT2
  } reg_sel_e;
endpackage

// File: rtl/intdist_decode.sv
module intdist_decode
  import intdist_pkg::*;
#(
  parameter int MAX_SHARED = 32,
  parameter int CNT_W      = 10,
  localparam int IDX_W     = (MAX_SHARED > 1) ? $clog2(MAX_SHARED) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  shared_cnt,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  route_idx
);
  logic              legal;
  logic [ADDR_W-1:0] roff;
  logic [GID_W-1:0]  gid;
  logic [GID_W-1:0]  sid;
  logic              in_route;
  logic              wired;

  assign legal    = (size == SIZE_WORD) && (addr[1:0] == 2'b00);
  assign in_route = (addr >= ROUTE_LO) && (addr < ROUTE_HI);
  assign roff     = addr - ROUTE_LO;
  assign gid      = roff[GID_W+2:3];
  assign sid      = gid - GID_W'(PRIV_CNT);
  assign wired    = (int'(gid) >= PRIV_CNT) && (int'(sid) < int'(shared_cnt))
                    && (int'(sid) < MAX_SHARED);
  assign route_idx = sid[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (legal) begin
      if (addr == OFF_CTRL)                    sel = SEL_CTRL;
      else if (addr == OFF_TYPE)               sel = SEL_TYPE;
      else if (addr == OFF_IMPL)               sel = SEL_IMPL;
      else if (addr == OFF_IDENT2)             sel = SEL_IDENT2;
      else if (in_route && wired && !addr[2])  sel = SEL_ROUTE;
    end
  end
endmodule

// File: rtl/intdist_ctrl.sv
module intdist_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic ctrl_bit,
  output logic enable,
  output logic wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      wake   <= 1'b0;
    end else begin
      wake <= ctrl_we && ctrl_bit && !enable;
      if (ctrl_we) enable <= ctrl_bit;
    end
  end
endmodule

// File: rtl/intdist_route.sv
module intdist_route
  import intdist_pkg::*;
#(
  parameter int MAX_SHARED = 32,
  localparam int IDX_W     = (MAX_SHARED > 1) ? $clog2(MAX_SHARED) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [AFF_W-1:0]            wdata,
  output logic [AFF_W-1:0]            rd_aff,
  output logic [MAX_SHARED*AFF_W-1:0] aff_flat
);
  logic [AFF_W-1:0] ent [MAX_SHARED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SHARED; i++) ent[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < MAX_SHARED; i++)
        if (int'(idx) == i) ent[i] <= wdata;
    end
  end

  always_comb begin
    rd_aff = '0;
    for (int i = 0; i < MAX_SHARED; i++)
      if (int'(idx) == i) rd_aff = ent[i];
  end

  for (genvar g = 0; g < MAX_SHARED; g++) begin : g_flat
    assign aff_flat[g*AFF_W +: AFF_W] = ent[g];
  end
endmodule

// File: rtl/intdist_regs.sv
module intdist_regs
  import intdist_pkg::*;
#(
  parameter int          MAX_SHARED = 32,
  parameter int          CNT_W      = 10,
  parameter logic [31:0] IIDR_VALUE = 32'h4B00_043B,
  localparam int         IDX_W      = (MAX_SHARED > 1) ? $clog2(MAX_SHARED) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [1:0]                  bus_size,
  input  logic [31:0]                 bus_wdata,
  input  logic [CNT_W-1:0]            cfg_shared_cnt,
  input  logic                        cfg_msg_irq,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  output logic                        dist_enable,
  output logic                        dist_wake,
  output logic [MAX_SHARED*24-1:0]    route_aff
);
  reg_sel_e         sel;
  logic [IDX_W-1:0] ridx;
  logic [AFF_W-1:0] rd_aff;
  logic [CNT_W:0]   total;
  logic [4:0]       lines;
  logic [31:0]      type_word;
  logic [31:0]      rval;

  intdist_decode #(.MAX_SHARED(MAX_SHARED), .CNT_W(CNT_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .shared_cnt(cfg_shared_cnt),
    .sel(sel), .route_idx(ridx)
  );

  intdist_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr && (sel == SEL_CTRL)), .ctrl_bit(bus_wdata[0]),
    .enable(dist_enable), .wake(dist_wake)
  );

  intdist_route #(.MAX_SHARED(MAX_SHARED)) u_route (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && (sel == SEL_ROUTE)), .idx(ridx),
    .wdata(bus_wdata[AFF_W-1:0]), .rd_aff(rd_aff), .aff_flat(route_aff)
  );

  assign total = {1'b0, cfg_shared_cnt} + (CNT_W+1)'(PRIV_CNT);
  assign lines = 5'((total >> 5) - 1'b1);

  always_comb begin
    type_word        = '0;
    type_word[4:0]   = lines;
    type_word[17]    = cfg_msg_irq;
    type_word[23:19] = cfg_msg_irq ? 5'(MSG_ID_BITS - 1) : 5'(LOW_ID_BITS - 1);
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rval = {25'd0, 1'b1, 1'b0, 1'b1, 3'd0, dist_enable};
      SEL_TYPE:   rval = type_word;
      SEL_IMPL:   rval = IIDR_VALUE;
      SEL_ROUTE:  rval = {8'd0, rd_aff};
      SEL_IDENT2: rval = 32'h0000_003B;
      default:    rval = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rval;
    end
  end
endmodule

// File: rtl/intdist_regs_chk.sv
module intdist_regs_chk #(
  parameter int MAX_SHARED = 32,
  parameter int CNT_W      = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [15:0]              bus_addr,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [1:0]               bus_size,
  input logic [31:0]              bus_wdata,
  input logic [CNT_W-1:0]         cfg_shared_cnt,
  input logic                     cfg_msg_irq,
  input logic [31:0]              bus_rdata,
  input logic                     bus_rvalid,
  input logic                     dist_enable,
  input logic                     dist_wake,
  input logic [MAX_SHARED*24-1:0] route_aff
);
  p_wake_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dist_wake |-> (dist_enable && !$past(dist_enable)));

  p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dist_wake |=> !dist_wake);

  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 16'h0000 && bus_size == 2'd2) |=> $stable(dist_enable));

  p_rvalid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_bad_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_size != 2'd2 || bus_addr[1:0] != 2'b00)) |=> (bus_rdata == 32'd0));

  p_aff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(route_aff));
endmodule

bind intdist_regs intdist_regs_chk #(.MAX_SHARED(MAX_SHARED), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/intdist_regs_test.sv
module intdist_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS  = 48;
  localparam int CW    = 10;
  localparam logic [31:0] IIDR = 32'h4B00_043B;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [1:0]        bus_size = 2'd2;
  logic [31:0]       bus_wdata = '0;
  logic [CW-1:0]     cfg_shared_cnt = CW'(40);
  logic              cfg_msg_irq = 1'b0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic              dist_enable;
  logic              dist_wake;
  logic [MAXS*24-1:0] route_aff;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intdist_regs #(.MAX_SHARED(MAXS), .CNT_W(CW), .IIDR_VALUE(IIDR)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'd2;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_size = 2'd2;
    check("R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] raddr(input int id);
    return 16'(32'h6000 + 8 * id);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R2 reset enable", {31'd0, dist_enable}, 32'd0);
    check("R3 reset wake", {31'd0, dist_wake}, 32'd0);
    check("R8 reset aff", {31'd0, (route_aff == '0)}, 32'd1);
    check("R12 reset rvalid", {31'd0, bus_rvalid}, 32'd0);
    do_rd(16'h0000, d); check("R1 ctrl reset read", d, 32'h50);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    do_wr(16'h0000, 32'hFFFF_FFFF);
    check("R3 wake pulse", {31'd0, dist_wake}, 32'd1);
    check("R2 enable set", {31'd0, dist_enable}, 32'd1);
    @(negedge clk);
    check("R3 wake one cycle", {31'd0, dist_wake}, 32'd0);
    do_rd(16'h0000, d); check("R1 ctrl read enabled", d, 32'h51);
    do_wr(16'h0000, 32'h1);
    check("R3 no wake when already on", {31'd0, dist_wake}, 32'd0);
    do_wr(16'h0000, 32'hFFFF_FFFE);
    check("R2 enable cleared", {31'd0, dist_enable}, 32'd0);
    check("R3 no wake on disable", {31'd0, dist_wake}, 32'd0);
    do_rd(16'h0000, d); check("R1 ctrl read disabled", d, 32'h50);
    do_rd(16'h000C, d); check("R1 offset 0xC zero", d, 32'h0);
  endtask

  task automatic t_type();
    logic [31:0] d;
    do_rd(16'h0004, d); check("R4 R5 type cnt40 nomsg", d, 32'h0048_0001);
    cfg_msg_irq = 1'b1; cfg_shared_cnt = CW'(100);
    do_rd(16'h0004, d); check("R4 R5 type cnt100 msg", d, 32'h007A_0003);
    cfg_shared_cnt = CW'(0);
    do_rd(16'h0004, d); check("R4 type cnt0", d, 32'h007A_0000);
    do_wr(16'h0004, 32'hFFFF_FFFF);
    do_rd(16'h0004, d); check("R6 type ignores write", d, 32'h007A_0000);
    cfg_msg_irq = 1'b0; cfg_shared_cnt = CW'(40);
    do_rd(16'h0008, d); check("R6 implementer", d, IIDR);
    do_wr(16'h0008, 32'h0);
    do_rd(16'h0008, d); check("R6 implementer ignores write", d, IIDR);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    do_rd(16'hFFE8, d); check("R7 ident2", d, 32'h3B);
    do_rd(16'hFFEC, d); check("R7 ident other", d, 32'h0);
    do_rd(16'hFFD0, d); check("R7 ident base", d, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    do_wr(raddr(32), 32'hAB12_3456);
    do_rd(raddr(32), d); check("R8 route id32 read", d, 32'h0012_3456);
    check("R8 route id32 output", {8'd0, route_aff[0 +: 24]}, 32'h0012_3456);
    do_wr(raddr(71), 32'h00FE_DCBA);
    do_rd(raddr(71), d); check("R8 route last wired", d, 32'h00FE_DCBA);
    check("R8 route last output", {8'd0, route_aff[39*24 +: 24]}, 32'h00FE_DCBA);
    do_wr(raddr(32) + 16'd4, 32'h0077_7777);
    do_rd(raddr(32) + 16'd4, d); check("R9 upper word zero", d, 32'h0);
    do_rd(raddr(32), d); check("R9 lower kept after upper write", d, 32'h0012_3456);
  endtask

  task automatic t_bound();
    logic [31:0] d;
    do_wr(raddr(72), 32'h0055_5555);
    do_rd(raddr(72), d); check("R10 unwired id reads zero", d, 32'h0);
    check("R10 unwired slot untouched", {8'd0, route_aff[40*24 +: 24]}, 32'h0);
    do_wr(raddr(5), 32'h0033_3333);
    do_rd(raddr(5), d); check("R10 private id reads zero", d, 32'h0);
    check("R10 outputs unchanged", {8'd0, route_aff[0 +: 24]}, 32'h0012_3456);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    do_wr(16'h0000, 32'h1, 2'd0);
    check("R11 byte write ctrl no effect", {31'd0, dist_enable}, 32'd0);
    do_rd(16'h0000, d, 2'd0); check("R11 byte read zero", d, 32'h0);
    do_rd(16'h0001, d); check("R11 misaligned read zero", d, 32'h0);
    do_wr(raddr(32), 32'h0011_1111, 2'd1);
    do_wr(raddr(32) + 16'd2, 32'h0022_2222);
    do_rd(raddr(32), d); check("R11 bad writes left route", d, 32'h0012_3456);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_type();
    t_ident();
    t_route();
    t_bound();
    t_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule